// File: doc/BRIEF.md
# Low-Power Gated Up/Down Counter with Scan Chain

This block is a binary counter whose width is set by a parameter. It counts up or down one step per clock according to a direction input. Its register is clocked through an internal gated clock, so the flops see clock edges only while the counter is enabled or while a scan shift is in progress. An idle counter therefore draws no clock power in its register.

The gate stores the enable in a storage element that is closed while the clock is high. A glitch on the enable during that phase cannot reach the gated clock. Two gate variants can be picked by parameter: a level-sensitive latch that is open while the clock is low, or a flop on the falling edge. A synchronous load overrides counting. In test mode the count bits are re-used as a serial shift chain, fed at the least significant bit and read out at the most significant bit. A terminal-count flag marks the last value before the count wraps in the current direction.

Top module: `gated_updown_counter`

## Requirements
- R1: While `rst_n` is low, `count` is zero at once, without waiting for a clock edge.
- R2: With `en`=1, `scan_en`=0, `load`=0 and `up`=1, each rising clock edge increases `count` by one.
- R3: With `en`=1, `scan_en`=0, `load`=0 and `up`=0, each rising clock edge decreases `count` by one.
- R4: With `en`=0 and `scan_en`=0, `count` holds its value whatever `load`, `load_data` and `up` are.
- R5: The count wraps modulo 2^WIDTH: all ones plus one gives zero, and zero minus one gives all ones.
- R6: With `en`=1, `scan_en`=0 and `load`=1, the next rising edge puts `load_data` into `count`, whatever `up` is.
- R7: With `scan_en`=1, each rising edge shifts `count` one place toward the MSB and puts `scan_in` into bit 0. This holds whatever `en`, `load` and `up` are.
- R8: `scan_out` always equals bit WIDTH-1 of `count`.
- R9: `tc` is 1 exactly when `up`=1 and `count` is all ones, or when `up`=0 and `count` is zero.
- R10: A pulse on `en` that starts and ends while `clk` is high has no effect on `count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock; the register uses a gated copy of it |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Count/load enable; it gates the register clock |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| load | input | 1 | Synchronous load request |
| load_data | input | WIDTH | Value taken by a load |
| scan_en | input | 1 | Test mode: the register becomes a shift chain and its clock is forced on |
| scan_in | input | 1 | Serial input to bit 0 of the chain |
| scan_out | output | 1 | Serial output, the MSB of the chain |
| count | output | WIDTH | Current count value |
| tc | output | 1 | Terminal count in the current direction |

## Verification
The assertions assume that `en` and `scan_en` change only while `clk` is low. They read these inputs at the rising edge and take that value to be the one the gate stored. They also assume that every control input is stable across each rising edge. The bench drives all controls on the falling edge and samples one nanosecond after the rising edge. The only exception is the deliberate high-phase pulse on `en` for R10. That pulse is raised and dropped well inside the high phase and has settled before the next rising edge.

// File: rtl/cgc_pkg.sv
`timescale 1ns/1ps
package cgc_pkg;
   // Storage element used to hold the enable inside the clock gate
   typedef enum logic {
      GATE_LATCH   = 1'b0,   // level latch, transparent while clk is low
      GATE_NEGFLOP = 1'b1    // flop on the falling edge of clk
   } gate_style_e;

   localparam int unsigned MIN_WIDTH = 2;
   localparam int unsigned MAX_WIDTH = 64;
endpackage

// File: rtl/cgc_clock_gate.sv
`timescale 1ns/1ps
module cgc_clock_gate #(
   parameter cgc_pkg::gate_style_e STYLE = cgc_pkg::GATE_LATCH
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic force_on,
   output logic gclk
);
   logic want;
   logic en_held;

   assign want = en | force_on;

   generate
      if (STYLE == cgc_pkg::GATE_LATCH) begin : g_latch
         // Open only while clk is low; closed during the high phase
         always_latch begin
            if (!clk) en_held = want;
         end
      end else begin : g_negflop
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) en_held <= 1'b0;
            else        en_held <= want;
         end
      end
   endgenerate

   assign gclk = clk & en_held;

   if (STYLE == cgc_pkg::GATE_LATCH) begin : g_rst_unused
      logic unused_rst;
      assign unused_rst = rst_n;
   end
endmodule

// File: rtl/cgc_next_state.sv
`timescale 1ns/1ps
module cgc_next_state #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] q,
   input  logic             up,
   input  logic             load,
   input  logic [WIDTH-1:0] load_data,
   input  logic             scan_en,
   input  logic             scan_in,
   output logic [WIDTH-1:0] d
);
   localparam int unsigned MSB = WIDTH - 1;

   logic [WIDTH-1:0] step;
   logic [WIDTH-1:0] counted;
   logic [WIDTH-1:0] shifted;

   // +1 when counting up, all ones (-1) when counting down
   assign step    = {{(WIDTH-1){~up}}, 1'b1};
   assign counted = q + step;

   generate
      for (genvar b = 0; b <= MSB; b++) begin : g_bit
         if (b == 0) begin : g_head
            assign shifted[b] = scan_in;
         end else begin : g_body
            assign shifted[b] = q[b-1];
         end
         // priority: scan, then load, then count
         always_comb begin
            if (scan_en)   d[b] = shifted[b];
            else if (load) d[b] = load_data[b];
            else           d[b] = counted[b];
         end
      end
   endgenerate
endmodule

// File: rtl/cgc_terminal.sv
`timescale 1ns/1ps
module cgc_terminal #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] q,
   input  logic             up,
   output logic             tc
);
   logic at_top;
   logic at_bottom;

   assign at_top    = &q;
   assign at_bottom = ~|q;
   assign tc        = up ? at_top : at_bottom;
endmodule

// File: rtl/gated_updown_counter.sv
`timescale 1ns/1ps
module gated_updown_counter #(
   parameter int unsigned          WIDTH      = 8,
   parameter cgc_pkg::gate_style_e GATE_STYLE = cgc_pkg::GATE_LATCH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             up,
   input  logic             load,
   input  logic [WIDTH-1:0] load_data,
   input  logic             scan_en,
   input  logic             scan_in,
   output logic             scan_out,
   output logic [WIDTH-1:0] count,
   output logic             tc
);
   initial begin : elab_checks
      a_width_range : assert (WIDTH >= cgc_pkg::MIN_WIDTH && WIDTH <= cgc_pkg::MAX_WIDTH)
         else $error("gated_updown_counter: WIDTH %0d out of range", WIDTH);
   end

   logic             gclk;
   logic [WIDTH-1:0] q;
   logic [WIDTH-1:0] d;

   cgc_clock_gate #(.STYLE(GATE_STYLE)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .force_on (scan_en),
      .gclk     (gclk)
   );

   cgc_next_state #(.WIDTH(WIDTH)) u_next (
      .q         (q),
      .up        (up),
      .load      (load),
      .load_data (load_data),
      .scan_en   (scan_en),
      .scan_in   (scan_in),
      .d         (d)
   );

   always_ff @(posedge gclk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

   cgc_terminal #(.WIDTH(WIDTH)) u_term (
      .q  (q),
      .up (up),
      .tc (tc)
   );

   assign count    = q;
   assign scan_out = q[WIDTH-1];
endmodule

// File: rtl/gated_updown_counter_chk.sv
`timescale 1ns/1ps
module gated_updown_counter_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             up,
   input logic             load,
   input logic [WIDTH-1:0] load_data,
   input logic             scan_en,
   input logic             scan_in,
   input logic             scan_out,
   input logic [WIDTH-1:0] count,
   input logic             tc
);
   logic unused_tc;
   assign unused_tc = tc;

   p_count_up_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (en && !scan_en && !load && up) |=> count == WIDTH'($past(count) + 1'b1));

   p_count_down_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (en && !scan_en && !load && !up) |=> count == WIDTH'($past(count) - 1'b1));

   p_hold_idle_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !scan_en) |=> $stable(count));

   p_wrap_up_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (en && !scan_en && !load && up && count == '1) |=> count == '0);

   p_load_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (en && !scan_en && load) |=> count == $past(load_data));

   p_scan_shift_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      scan_en |=> count == {$past(count[WIDTH-2:0]), $past(scan_in)});

   p_scan_out_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      scan_en |=> scan_out == $past(count[WIDTH-2]));
endmodule

bind gated_updown_counter gated_updown_counter_chk #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (en),
   .up        (up),
   .load      (load),
   .load_data (load_data),
   .scan_en   (scan_en),
   .scan_in   (scan_in),
   .scan_out  (scan_out),
   .count     (count),
   .tc        (tc)
);

// File: tb/gated_updown_counter_tb.sv
`timescale 1ns/1ps
module gated_updown_counter_tb;
   localparam int unsigned W    = 4;
   localparam int unsigned TOP  = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         en = 1'b0;
   logic         up = 1'b0;
   logic         load = 1'b0;
   logic [W-1:0] load_data = '0;
   logic         scan_en = 1'b0;
   logic         scan_in = 1'b0;
   logic         scan_out;
   logic [W-1:0] count;
   logic         tc;

   int n_vec = 0;
   int n_bad = 0;
   logic [W-1:0] exp_cnt;

   always #2.5 clk = ~clk;   // 200 MHz

   gated_updown_counter #(.WIDTH(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .up(up), .load(load),
      .load_data(load_data), .scan_en(scan_en), .scan_in(scan_in),
      .scan_out(scan_out), .count(count), .tc(tc)
   );

   task automatic check(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int exp_tc(input logic dir, input logic [W-1:0] v);
      return dir ? int'(v == W'(TOP)) : int'(v == '0);
   endfunction

   // drive on falling edge, sample 1 ns after the following rising edge
   task automatic cycle();
      @(posedge clk);
      #1;
   endtask

   initial begin : watchdog
      #1000000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : main
      // R1 reset state, R9 flag at zero in both directions
      #4;
      check("R1 count in reset", int'(count), 0);
      up = 1'b0; #0.5;
      check("R9 tc down at zero", int'(tc), 1);
      up = 1'b1; #0.5;
      check("R9 tc up at zero", int'(tc), 0);
      @(negedge clk); rst_n = 1'b1;
      exp_cnt = '0;

      // R2, R5, R9: count up across the wrap
      @(negedge clk); en = 1'b1; up = 1'b1;
      for (int i = 0; i < 20; i++) begin
         cycle();
         exp_cnt = exp_cnt + 1'b1;
         check("R2 up count", int'(count), int'(exp_cnt));
         check("R9 tc up", int'(tc), exp_tc(1'b1, exp_cnt));
      end
      // R3, R5: count down across the wrap
      @(negedge clk); up = 1'b0;
      for (int i = 0; i < 22; i++) begin
         cycle();
         exp_cnt = exp_cnt - 1'b1;
         check("R3 down count", int'(count), int'(exp_cnt));
         check("R9 tc down", int'(tc), exp_tc(1'b0, exp_cnt));
         if (exp_cnt == W'(TOP)) check("R5 wrap down to all ones", int'(count), int'(TOP));
      end

      // R4: disabled, load and direction ignored
      @(negedge clk); en = 1'b0; load = 1'b1; load_data = 4'hA;
      for (int i = 0; i < 6; i++) begin
         up = i[0];
         cycle();
         check("R4 hold while disabled", int'(count), int'(exp_cnt));
         @(negedge clk);
      end

      // R6: load every value, direction alternating
      en = 1'b1;
      for (int v = 0; v <= int'(TOP); v++) begin
         load_data = W'(v); up = v[0];
         cycle();
         exp_cnt = W'(v);
         check("R6 load", int'(count), v);
         @(negedge clk);
      end
      // count after load resumes from loaded value
      load = 1'b0; up = 1'b1;
      cycle();
      exp_cnt = exp_cnt + 1'b1;
      check("R5 wrap up after load of all ones", int'(count), int'(exp_cnt));

      // R7, R8: scan shift overrides enable and load
      @(negedge clk); scan_en = 1'b1; en = 1'b0; load = 1'b1; load_data = 4'h5;
      for (int i = 0; i < 12; i++) begin
         scan_in = ((12'b1011_0011_1001 >> i) & 1) != 0;
         en = i[1];
         cycle();
         exp_cnt = {exp_cnt[W-2:0], scan_in};
         check("R7 scan shift", int'(count), int'(exp_cnt));
         check("R8 scan out", int'(scan_out), int'(exp_cnt[W-1]));
         @(negedge clk);
      end
      scan_en = 1'b0; load = 1'b0; en = 1'b0; up = 1'b1;

      // R10: enable pulse inside the high phase does nothing
      for (int i = 0; i < 3; i++) begin
         @(posedge clk);
         #0.5 en = 1'b1;
         #1   en = 1'b0;
         cycle();
         check("R10 high-phase enable pulse", int'(count), int'(exp_cnt));
      end

      // R1: asynchronous reset between edges
      @(negedge clk); en = 1'b1;
      cycle();
      #0.5 rst_n = 1'b0;
      #0.5;
      check("R1 async reset", int'(count), 0);
      @(negedge clk); rst_n = 1'b1; en = 1'b0;

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule